// File: doc/BRIEF.md
# Serial Music-Instrument Byte Stream Message Parser

This block takes the raw single-wire serial stream used by electronic music instruments (31,250 bit/s, one start bit, eight data bits sent least significant first, one stop bit) and recovers bytes with a 16x oversampling receiver clocked from the system clock. A frame whose stop bit reads low is reported on a framing-error strobe and is thrown away. Each good byte is then classified by its top bit. A set top bit marks a status byte. A clear top bit marks a 7-bit data byte.

The assembler keeps the last channel status (running status) and collects one or two data bytes, depending on the command. When a channel message is complete it raises a one-cycle message strobe with the command kind, the channel and both data fields. Note-on and note-off are decoded fully, and a note-on with zero velocity is turned into a note-off. Single-byte real-time codes (0xF8 to 0xFF) are taken out of the stream at once on a separate strobe. They may fall between the bytes of another message without disturbing it.

Top module: `midi_stream_parser`

## Requirements
- R1: A frame is a low start bit, eight data bits least significant bit first, and a high stop bit. The line idles high, and one bit lasts CLK_HZ/BAUD system clocks, sampled by a 16x oversampling tick.
- R2: A frame whose stop bit is low pulses `frame_err` for one cycle. Its byte produces neither a message nor a real-time strobe and leaves the assembly state unchanged.
- R3: A channel status byte 0x80 to 0xEF sets the channel (its low nibble) and the kind (its bits 6:4): 0 note-off, 1 note-on, 2 key pressure, 3 controller, 4 program, 5 channel pressure, 6 pitch bend. `msg_kind` never reads 7.
- R4: Status 0x9n followed by a note byte and a velocity byte gives a message of kind 1 with `msg_d1` as the note and `msg_d2` as the velocity. When the velocity is 0, the message is reported as kind 0.
- R5: Kinds 0, 1, 2, 3 and 6 complete after two data bytes (first byte in `msg_d1`, second in `msg_d2`). Kinds 4 and 5 complete after one data byte, with `msg_d2` = 0.
- R6: Data bytes that follow a completed message without a new status byte reuse the stored channel status (running status).
- R7: A byte 0xF8 to 0xFF pulses `rt_valid` with `rt_code` equal to the byte one cycle after the byte is received. It changes neither the running status nor the data bytes already collected.
- R8: A data byte that arrives with no running status in effect is dropped. This holds after reset and after any status byte 0xF0 to 0xF7, which cancels running status.
- R9: A new channel status byte that arrives in the middle of a message discards the partial message. Assembly then starts over under the new status.
- R10: After reset all strobes are low and no running status is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| midi_rx | input | 1 | Serial input line, idle high |
| msg_valid | output | 1 | One-cycle strobe: a channel message is complete |
| msg_kind | output | 3 | Command kind (status bits 6:4, note-on with velocity 0 reads 0) |
| msg_chan | output | 4 | Channel number, counted from zero |
| msg_d1 | output | 7 | First data byte |
| msg_d2 | output | 7 | Second data byte (0 for one-data-byte kinds) |
| rt_valid | output | 1 | One-cycle strobe: a real-time byte arrived |
| rt_code | output | 8 | The real-time byte |
| frame_err | output | 1 | One-cycle strobe: stop bit was low, byte discarded |

## Verification
The two functions that overlap in time are real-time extraction and channel-message assembly: a real-time strobe must fire while a note-on is half collected. The bench places a timing-clock byte between the note byte and the velocity byte, and also between two running-status data bytes. It then judges that the real-time strobe appears with its code, that no message strobe fires early, and that the message which follows still carries the original note, velocity and channel. A bad-stop frame sent in the middle of a message is judged in the same way: it must leave the partial message intact.

// File: rtl/midi_pkg.sv
package midi_pkg;

  localparam int BYTE_W = 8;
  localparam int DATA_W = 7;
  localparam int CHAN_W = 4;
  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] KIND_NOTE_OFF = 3'd0;
  localparam logic [KIND_W-1:0] KIND_NOTE_ON  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_PROGRAM  = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CHPRESS  = 3'd5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

  // real-time codes occupy the top eight status values
  function automatic logic is_realtime(input logic [BYTE_W-1:0] b);
    return b[7:3] == 5'b11111;
  endfunction

  // status byte that opens a channel message
  function automatic logic is_channel_status(input logic [BYTE_W-1:0] b);
    return b[7] && (b[6:4] != 3'b111);
  endfunction

  // number of data bytes that complete a channel message
  function automatic logic [1:0] data_len(input logic [BYTE_W-1:0] status);
    return ((status[6:4] == KIND_PROGRAM) || (status[6:4] == KIND_CHPRESS)) ? 2'd1 : 2'd2;
  endfunction

  // reported kind, with zero-velocity note-on folded into note-off
  function automatic logic [KIND_W-1:0] kind_of(input logic [BYTE_W-1:0] status,
                                                input logic [DATA_W-1:0] second);
    if (status[6:4] == KIND_NOTE_ON && second == '0)
      return KIND_NOTE_OFF;
    return status[6:4];
  endfunction

endpackage

// File: rtl/midi_os_tick.sv
module midi_os_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx
  import midi_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_dat,
  output logic              frame_err
);
  localparam int OVS_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam logic [OVS_W-1:0] MID  = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] FULL = OVS_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  logic [1:0]           sync_q;
  logic                 rx_s;
  rx_state_t            state;
  logic [OVS_W-1:0]     os_cnt;
  logic [BIT_W-1:0]     bit_idx;
  logic [DATA_BITS-1:0] shreg;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      byte_stb  <= 1'b0;
      byte_dat  <= '0;
      frame_err <= 1'b0;
    end else begin
      byte_stb  <= 1'b0;
      frame_err <= 1'b0;
      case (state)
        RX_IDLE: if (tick && !rx_s) begin
          state  <= RX_START;
          os_cnt <= '0;
        end
        RX_START: if (tick) begin
          if (os_cnt == MID) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_cnt == FULL) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[DATA_BITS-1:1]};
            if (bit_idx == LAST_BIT) state <= RX_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_cnt == FULL) begin
            os_cnt <= '0;
            if (rx_s) begin
              byte_stb <= 1'b1;
              byte_dat <= BYTE_W'(shreg);
              state    <= RX_IDLE;
            end else begin
              frame_err <= 1'b1;
              state     <= RX_HOLD;
            end
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_HOLD: if (rx_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/midi_msg_asm.sv
module midi_msg_asm
  import midi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              msg_valid,
  output logic [KIND_W-1:0] msg_kind,
  output logic [CHAN_W-1:0] msg_chan,
  output logic [DATA_W-1:0] msg_d1,
  output logic [DATA_W-1:0] msg_d2,
  output logic              rt_valid,
  output logic [BYTE_W-1:0] rt_code,
  output logic              stat_live
);
  logic [BYTE_W-1:0] run_stat;
  logic              have_d1;
  logic [DATA_W-1:0] held_d1;
  logic [DATA_W-1:0] in_val;

  assign in_val = byte_dat[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_stat  <= '0;
      stat_live <= 1'b0;
      have_d1   <= 1'b0;
      held_d1   <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= '0;
      msg_chan  <= '0;
      msg_d1    <= '0;
      msg_d2    <= '0;
      rt_valid  <= 1'b0;
      rt_code   <= '0;
    end else begin
      msg_valid <= 1'b0;
      rt_valid  <= 1'b0;
      if (byte_stb) begin
        if (is_realtime(byte_dat)) begin
          rt_valid <= 1'b1;
          rt_code  <= byte_dat;
        end else if (byte_dat[7]) begin
          have_d1 <= 1'b0;
          if (is_channel_status(byte_dat)) begin
            run_stat  <= byte_dat;
            stat_live <= 1'b1;
          end else begin
            stat_live <= 1'b0;
          end
        end else if (stat_live) begin
          if (data_len(run_stat) == 2'd1) begin
            msg_valid <= 1'b1;
            msg_kind  <= kind_of(run_stat, '0);
            msg_chan  <= run_stat[CHAN_W-1:0];
            msg_d1    <= in_val;
            msg_d2    <= '0;
          end else if (!have_d1) begin
            held_d1 <= in_val;
            have_d1 <= 1'b1;
          end else begin
            msg_valid <= 1'b1;
            msg_kind  <= kind_of(run_stat, in_val);
            msg_chan  <= run_stat[CHAN_W-1:0];
            msg_d1    <= held_d1;
            msg_d2    <= in_val;
            have_d1   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/midi_stream_parser.sv
module midi_stream_parser
  import midi_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 31_250,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              midi_rx,
  output logic              msg_valid,
  output logic [KIND_W-1:0] msg_kind,
  output logic [CHAN_W-1:0] msg_chan,
  output logic [DATA_W-1:0] msg_d1,
  output logic [DATA_W-1:0] msg_d2,
  output logic              rt_valid,
  output logic [BYTE_W-1:0] rt_code,
  output logic              frame_err
);
  localparam int TICK_DIV = (CLK_HZ / (BAUD * OVS) < 2) ? 2 : CLK_HZ / (BAUD * OVS);

  logic              os_tick;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_dat;
  logic              stat_live;

  midi_os_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (os_tick)
  );

  midi_uart_rx #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .line_in   (midi_rx),
    .byte_stb  (byte_stb),
    .byte_dat  (byte_dat),
    .frame_err (frame_err)
  );

  midi_msg_asm u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb  (byte_stb),
    .byte_dat  (byte_dat),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .msg_chan  (msg_chan),
    .msg_d1    (msg_d1),
    .msg_d2    (msg_d2),
    .rt_valid  (rt_valid),
    .rt_code   (rt_code),
    .stat_live (stat_live)
  );
endmodule

// File: rtl/midi_stream_parser_chk.sv
module midi_stream_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_stb,
  input logic [7:0] byte_dat,
  input logic       frame_err,
  input logic       stat_live,
  input logic       msg_valid,
  input logic [2:0] msg_kind,
  input logic [6:0] msg_d2,
  input logic       rt_valid,
  input logic [7:0] rt_code
);
  // R7: real-time byte reported on the next cycle with its code
  a_r7_rt_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_dat[7:3] == 5'b11111) |=> (rt_valid && rt_code == $past(byte_dat)));

  // R7: real-time byte leaves running status alone and emits no message
  a_r7_rt_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_dat[7:3] == 5'b11111) |=> ($stable(stat_live) && !msg_valid));

  // R8: data with no running status never completes a message
  a_r8_orphan_data: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !byte_dat[7] && !stat_live) |=> !msg_valid);

  // R2: a bad frame yields no downstream strobe
  a_r2_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> (!msg_valid && !rt_valid));

  // R3: kind 7 is never reported
  a_r3_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_kind != 3'd7));

  // R4: a note-on always carries a nonzero velocity
  a_r4_noteon_vel: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 3'd1) |-> (msg_d2 != 7'd0));
endmodule

bind midi_stream_parser midi_stream_parser_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_stb  (byte_stb),
  .byte_dat  (byte_dat),
  .frame_err (frame_err),
  .stat_live (stat_live),
  .msg_valid (msg_valid),
  .msg_kind  (msg_kind),
  .msg_d2    (msg_d2),
  .rt_valid  (rt_valid),
  .rt_code   (rt_code)
);

// File: tb/midi_stream_parser_test.sv
module midi_stream_parser_test;
  localparam int CLK_HZ = 1_000_000;
  localparam int BAUD   = 31_250;
  localparam int BIT_CLKS = CLK_HZ / BAUD;   // 32 clocks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       midi_rx = 1'b1;
  logic       msg_valid;
  logic [2:0] msg_kind;
  logic [3:0] msg_chan;
  logic [6:0] msg_d1;
  logic [6:0] msg_d2;
  logic       rt_valid;
  logic [7:0] rt_code;
  logic       frame_err;

  int checks = 0;
  int failures = 0;
  int msg_n = 0, rt_n = 0, fe_n = 0;
  int last_kind, last_chan, last_d1, last_d2, last_rt;
  bit any_strobe_after_reset = 0;

  always #5 clk = ~clk;

  midi_stream_parser #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .midi_rx(midi_rx),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_chan(msg_chan),
    .msg_d1(msg_d1), .msg_d2(msg_d2),
    .rt_valid(rt_valid), .rt_code(rt_code), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_valid) begin
        msg_n++; last_kind = msg_kind; last_chan = msg_chan;
        last_d1 = msg_d1; last_d2 = msg_d2;
      end
      if (rt_valid) begin rt_n++; last_rt = rt_code; end
      if (frame_err) fe_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop = 1'b1);
    midi_rx = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_rx = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    midi_rx = good_stop;
    repeat (BIT_CLKS) @(negedge clk);
    midi_rx = 1'b1;
    repeat (BIT_CLKS / 2) @(negedge clk);
  endtask

  task automatic expect_msg(input string req, input int n0, input int k, input int c,
                            input int d1, input int d2);
    chk(req, "message count", msg_n, n0 + 1);
    chk(req, "kind", last_kind, k);
    chk(req, "channel", last_chan, c);
    chk(req, "data1", last_d1, d1);
    chk(req, "data2", last_d2, d2);
  endtask

  task automatic t_reset;
    // R10: strobes low after reset, no running status held
    chk("R10", "msg_valid", msg_valid, 0);
    chk("R10", "rt_valid", rt_valid, 0);
    chk("R10", "frame_err", frame_err, 0);
    chk("R10", "strobes during reset release", any_strobe_after_reset, 0);
    begin
      int n0 = msg_n;
      send_byte(8'h33); send_byte(8'h22);
      chk("R8", "data with no status after reset", msg_n, n0);
    end
  endtask

  task automatic t_note_on;
    int n0 = msg_n;
    send_byte(8'h93); send_byte(8'h3C);
    chk("R4", "no message after one data byte", msg_n, n0);
    send_byte(8'h40);
    expect_msg("R4", n0, 1, 3, 60, 64);   // R1 framing, R3 channel/kind
  endtask

  task automatic t_vel_zero;
    int n0 = msg_n;
    send_byte(8'h90); send_byte(8'h3C); send_byte(8'h00);
    expect_msg("R4", n0, 0, 0, 60, 0);
  endtask

  task automatic t_note_off_running;
    int n0 = msg_n;
    send_byte(8'h85); send_byte(8'h10); send_byte(8'h20);
    expect_msg("R3", n0, 0, 5, 16, 32);
    n0 = msg_n;
    send_byte(8'h11); send_byte(8'h7F);
    expect_msg("R6", n0, 0, 5, 17, 127);
  endtask

  task automatic t_rt_mid;
    int n0 = msg_n;
    int r0 = rt_n;
    send_byte(8'h92); send_byte(8'h40);
    send_byte(8'hF8);
    chk("R7", "rt count", rt_n, r0 + 1);
    chk("R7", "rt code", last_rt, 248);
    chk("R7", "no message from rt", msg_n, n0);
    send_byte(8'h50);
    expect_msg("R7", n0, 1, 2, 64, 80);
    n0 = msg_n;
    send_byte(8'h41); send_byte(8'hFE); send_byte(8'h00);
    chk("R7", "rt code 0xFE", last_rt, 254);
    expect_msg("R7", n0, 0, 2, 65, 0);
  endtask

  task automatic t_other_kinds;
    int n0 = msg_n;
    send_byte(8'hB1); send_byte(8'h07); send_byte(8'h64);
    expect_msg("R5", n0, 3, 1, 7, 100);
    n0 = msg_n;
    send_byte(8'hC4); send_byte(8'h05);
    expect_msg("R5", n0, 4, 4, 5, 0);
    n0 = msg_n;
    send_byte(8'h09);
    expect_msg("R5", n0, 4, 4, 9, 0);     // running status, one byte
    n0 = msg_n;
    send_byte(8'hEF); send_byte(8'h00); send_byte(8'h40);
    expect_msg("R5", n0, 6, 15, 0, 64);
  endtask

  task automatic t_system_cancels;
    int n0 = msg_n;
    send_byte(8'hA6); send_byte(8'hF2);
    send_byte(8'h10); send_byte(8'h20); send_byte(8'h30);
    chk("R8", "data after system common dropped", msg_n, n0);
  endtask

  task automatic t_restatus;
    int n0 = msg_n;
    send_byte(8'h90); send_byte(8'h30);
    send_byte(8'h87); send_byte(8'h31);
    chk("R9", "partial discarded", msg_n, n0);
    send_byte(8'h32);
    expect_msg("R9", n0, 0, 7, 49, 50);
  endtask

  task automatic t_frame;
    int n0 = msg_n;
    int f0 = fe_n;
    int r0 = rt_n;
    send_byte(8'h9A); send_byte(8'h30);
    send_byte(8'hF8, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R2", "frame error count", fe_n, f0 + 1);
    chk("R2", "bad rt byte not reported", rt_n, r0);
    send_byte(8'h40, 1'b0);
    repeat (BIT_CLKS) @(negedge clk);
    chk("R2", "bad data byte not used", msg_n, n0);
    send_byte(8'h45);
    expect_msg("R2", n0, 1, 10, 48, 69);
    chk("R1", "good frames raise no error", fe_n, f0 + 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    any_strobe_after_reset = msg_valid | rt_valid | frame_err;
    t_reset;
    t_note_on;
    t_vel_zero;
    t_note_off_running;
    t_rt_mid;
    t_other_kinds;
    t_system_cancels;
    t_restatus;
    t_frame;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule